// File: doc/BRIEF.md
# Split-Lane to Wide Data Bus Steering Controller

This block drives the buffer enables and direction controls that join two byte-wide memory banks to a bus with two separate 8-bit lanes. One lane carries bytes from the bus into the board (the Data-Out lane) and one carries bytes from the board out to the bus (the Data-In lane). The even bank holds the bytes at A0=0 and the odd bank holds the bytes at A0=1. A 16-bit transfer uses both lanes together as one bidirectional 16-bit path, with both banks enabled at once.

A byte-wide access to the odd bank on a write, or to the even bank on a read, must cross between the two sides through a bridge buffer. The controller picks the route from the strobe direction, the requested width and A0. It also raises an acknowledge for a 16-bit request. Every output is registered, so it reflects the inputs sampled at the previous rising clock edge. The memory arrays and the bus drivers lie outside the block.

Top module: `lane_steer_top`

## Requirements
- R1: While `rst` is high, and at the first rising edge where it is sampled high, every output goes to 0.
- R2: Every output is registered. It takes the value decoded from the inputs sampled at the previous rising edge of `clk`.
- R3: A transfer is active only when `sel`=1 and exactly one of `rd` and `wr` is 1. With no active transfer, every lane, bridge and bank enable and every direction output is 0. This includes the case where both strobes are 1.
- R4: Active write with `wide`=1 and `a0`=0: `do_en`=1 and `di_en`=1, each with direction 0 (bus to board). `even_we`=1 and `odd_we`=1. The bridge and both output enables are 0.
- R5: Active read with `wide`=1 and `a0`=0: `do_en`, `do_dir`, `di_en` and `di_dir` are all 1 (direction 1 means board to bus). `even_oe`=1 and `odd_oe`=1. The bridge and both write enables are 0.
- R6: Active byte write at `a0`=0: only `do_en`=1 (with `do_dir`=0) and `even_we`=1.
- R7: Active byte write at `a0`=1: `do_en`=1 with `do_dir`=0, `br_en`=1 with `br_dir`=0 (from the Data-Out side toward the odd bank), and `odd_we`=1. Nothing else is enabled.
- R8: Active byte read at `a0`=0: `br_en`=1 with `br_dir`=1 (from the even bank onto the Data-In lane) and `even_oe`=1. Both lane buffers are 0.
- R9: Active byte read at `a0`=1: `do_en`=1 with `do_dir`=1 and `odd_oe`=1. The bridge is 0.
- R10: A request with `wide`=1 and `a0`=1 is carried out exactly as the byte access at `a0`=1 (R7, R9), and `wide_ack` stays 0.
- R11: `wide_ack` is 1 exactly when `sel`=1, `wide`=1 and `a0`=0 were sampled, whatever the strobes are.
- R12: `br_en` and `di_en` are never both 1. On each bank, the output enable and the write enable are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Board selected for this cycle |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wide | input | 1 | 16-bit transfer requested |
| a0 | input | 1 | Byte address bit 0 |
| do_en | output | 1 | Data-Out lane buffer enable |
| do_dir | output | 1 | Data-Out lane direction, 1 = board to bus |
| di_en | output | 1 | Data-In lane buffer enable |
| di_dir | output | 1 | Data-In lane direction, 1 = board to bus |
| br_en | output | 1 | Bridge buffer enable |
| br_dir | output | 1 | Bridge direction, 1 = even bank to Data-In lane, 0 = Data-Out side to odd bank |
| even_oe | output | 1 | Even bank output enable |
| even_we | output | 1 | Even bank write enable |
| odd_oe | output | 1 | Odd bank output enable |
| odd_we | output | 1 | Odd bank write enable |
| wide_ack | output | 1 | 16-bit transfer acknowledge |

## Verification
The block has no size parameters, so the bench builds it in its only form, with two byte banks and one register stage. Because every input combination fits in a small table, the bench walks all sixteen strobe, width and A0 patterns with the board selected. Those patterns include the misaligned wide request and the case with both strobes active. Directed steps then cover deselection with live strobes, back-to-back changes that expose the one-cycle latency, and reset asserted in the middle of a transfer.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

  // Transfer classes decoded from strobes, width and A0.
  typedef enum logic [2:0] {
    XK_IDLE = 3'd0,
    XK_W8E  = 3'd1,
    XK_W8O  = 3'd2,
    XK_R8E  = 3'd3,
    XK_R8O  = 3'd4,
    XK_W16  = 3'd5,
    XK_R16  = 3'd6
  } xfer_kind_e;

  // Lane and bridge buffer controls.
  typedef struct packed {
    logic do_en;
    logic do_dir;
    logic di_en;
    logic di_dir;
    logic br_en;
    logic br_dir;
  } lane_ctl_t;

  localparam lane_ctl_t LANE_OFF = '{default: 1'b0};

endpackage

// File: rtl/lane_classify.sv
module lane_classify
  import lane_steer_pkg::*;
(
  input  logic       sel,
  input  logic       rd,
  input  logic       wr,
  input  logic       wide,
  input  logic       a0,
  output xfer_kind_e kind,
  output logic       ack
);

  logic active;
  logic aligned_wide;

  assign active       = sel & (rd ^ wr);
  assign aligned_wide = wide & ~a0;
  assign ack          = sel & aligned_wide;

  always_comb begin
    if (!active) begin
      kind = XK_IDLE;
    end else if (aligned_wide) begin
      kind = wr ? XK_W16 : XK_R16;
    end else if (wr) begin
      kind = a0 ? XK_W8O : XK_W8E;
    end else begin
      kind = a0 ? XK_R8O : XK_R8E;
    end
  end

endmodule

// File: rtl/lane_route.sv
module lane_route
  import lane_steer_pkg::*;
(
  input  xfer_kind_e kind,
  output lane_ctl_t  ctl
);

  always_comb begin
    ctl = LANE_OFF;
    unique case (kind)
      XK_W16: begin
        ctl.do_en = 1'b1;
        ctl.di_en = 1'b1;
      end
      XK_R16: begin
        ctl.do_en  = 1'b1;
        ctl.do_dir = 1'b1;
        ctl.di_en  = 1'b1;
        ctl.di_dir = 1'b1;
      end
      XK_W8E: begin
        ctl.do_en = 1'b1;
      end
      XK_W8O: begin
        ctl.do_en = 1'b1;
        ctl.br_en = 1'b1;
      end
      XK_R8E: begin
        ctl.br_en  = 1'b1;
        ctl.br_dir = 1'b1;
      end
      XK_R8O: begin
        ctl.do_en  = 1'b1;
        ctl.do_dir = 1'b1;
      end
      default: ctl = LANE_OFF;
    endcase
  end

endmodule

// File: rtl/bank_strobe.sv
module bank_strobe
  import lane_steer_pkg::*;
#(
  parameter bit ODD_BANK = 1'b0
) (
  input  xfer_kind_e kind,
  output logic       oe,
  output logic       we
);

  localparam xfer_kind_e BYTE_RD = ODD_BANK ? XK_R8O : XK_R8E;
  localparam xfer_kind_e BYTE_WR = ODD_BANK ? XK_W8O : XK_W8E;

  assign oe = (kind == XK_R16) || (kind == BYTE_RD);
  assign we = (kind == XK_W16) || (kind == BYTE_WR);

endmodule

// File: rtl/lane_steer_top.sv
module lane_steer_top
  import lane_steer_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic rd,
  input  logic wr,
  input  logic wide,
  input  logic a0,
  output logic do_en,
  output logic do_dir,
  output logic di_en,
  output logic di_dir,
  output logic br_en,
  output logic br_dir,
  output logic even_oe,
  output logic even_we,
  output logic odd_oe,
  output logic odd_we,
  output logic wide_ack
);

  localparam int NBANK = 2;

  xfer_kind_e       kind;
  logic             ack_d;
  lane_ctl_t        ctl_d;
  lane_ctl_t        ctl_q;
  logic [NBANK-1:0] oe_d, we_d;
  logic [NBANK-1:0] oe_q, we_q;
  logic             ack_q;
  logic             live_q;

  lane_classify u_classify (
    .sel  (sel),
    .rd   (rd),
    .wr   (wr),
    .wide (wide),
    .a0   (a0),
    .kind (kind),
    .ack  (ack_d)
  );

  lane_route u_route (
    .kind (kind),
    .ctl  (ctl_d)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bank_strobe #(.ODD_BANK(b[0])) u_bank (
      .kind (kind),
      .oe   (oe_d[b]),
      .we   (we_d[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= LANE_OFF;
      oe_q   <= '0;
      we_q   <= '0;
      ack_q  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      oe_q   <= oe_d;
      we_q   <= we_d;
      ack_q  <= ack_d;
      live_q <= 1'b1;
    end
  end

  assign do_en    = ctl_q.do_en;
  assign do_dir   = ctl_q.do_dir;
  assign di_en    = ctl_q.di_en;
  assign di_dir   = ctl_q.di_dir;
  assign br_en    = ctl_q.br_en;
  assign br_dir   = ctl_q.br_dir;
  assign even_oe  = oe_q[0];
  assign even_we  = we_q[0];
  assign odd_oe   = oe_q[1];
  assign odd_we   = we_q[1];
  assign wide_ack = ack_q;

  // R12: the bridge and the Data-In lane buffer never drive together
  p_no_contention_r12: assert property (@(posedge clk) disable iff (rst)
    !(br_en && di_en));

  // R12: a bank is never read and written in the same cycle
  p_bank_rw_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(even_oe && even_we) && !(odd_oe && odd_we));

  // R3: no enable follows a cycle without a selected, single-strobe transfer
  p_idle_gate_r3: assert property (@(posedge clk) disable iff (rst || !live_q)
    !($past(sel) && ($past(rd) ^ $past(wr))) |->
      !(do_en || di_en || br_en || even_oe || even_we || odd_oe || odd_we));

  // R11: acknowledge only after a selected, aligned wide request
  p_ack_src_r11: assert property (@(posedge clk) disable iff (rst || !live_q)
    wide_ack |-> $past(sel && wide && !a0));

  // R4: aligned wide write enables both banks for writing
  p_wide_write_r4: assert property (@(posedge clk) disable iff (rst || !live_q)
    $past(sel && wr && !rd && wide && !a0) |-> (even_we && odd_we && !br_en));

  // R7: odd byte write travels through the bridge toward the odd bank
  p_odd_write_r7: assert property (@(posedge clk) disable iff (rst || !live_q)
    $past(sel && wr && !rd && a0) |-> (br_en && !br_dir && odd_we && !even_we));

  // R1: outputs are cleared the cycle after reset is sampled
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> !(do_en || di_en || br_en || wide_ack));

endmodule

// File: tb/tb_lane_steer_top.sv
module tb_lane_steer_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  // expected order: do_en do_dir di_en di_dir br_en br_dir
  //                 even_oe even_we odd_oe odd_we wide_ack
  // index = {rd, wr, wide, a0}, all with sel=1
  localparam logic [10:0] EXP_TABLE [16] = '{
    11'b00000000000, // idle
    11'b00000000000, // idle
    11'b00000000001, // idle, aligned wide -> ack only (R11)
    11'b00000000000, // idle, misaligned wide
    11'b10000001000, // byte write even (R6)
    11'b10001000010, // byte write odd (R7)
    11'b10100001011, // wide write (R4)
    11'b10001000010, // misaligned wide write -> byte odd (R10)
    11'b00001110000, // byte read even (R8)
    11'b11000000100, // byte read odd (R9)
    11'b11110010101, // wide read (R5)
    11'b11000000100, // misaligned wide read -> byte odd (R10)
    11'b00000000000, // both strobes (R3)
    11'b00000000000, // both strobes (R3)
    11'b00000000001, // both strobes, aligned wide -> ack (R11)
    11'b00000000000  // both strobes
  };

  localparam string TAG_TABLE [16] = '{
    "R3", "R3", "R11", "R3", "R6", "R7", "R4", "R10",
    "R8", "R9", "R5", "R10", "R3", "R3", "R11", "R3"
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0, rd = 1'b0, wr = 1'b0, wide = 1'b0, a0 = 1'b0;
  logic do_en, do_dir, di_en, di_dir, br_en, br_dir;
  logic even_oe, even_we, odd_oe, odd_we, wide_ack;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lane_steer_top dut (
    .clk(clk), .rst(rst), .sel(sel), .rd(rd), .wr(wr), .wide(wide), .a0(a0),
    .do_en(do_en), .do_dir(do_dir), .di_en(di_en), .di_dir(di_dir),
    .br_en(br_en), .br_dir(br_dir), .even_oe(even_oe), .even_we(even_we),
    .odd_oe(odd_oe), .odd_we(odd_we), .wide_ack(wide_ack)
  );

  function automatic logic [10:0] outs();
    return {do_en, do_dir, di_en, di_dir, br_en, br_dir,
            even_oe, even_we, odd_oe, odd_we, wide_ack};
  endfunction

  task automatic check(input string tag, input logic [10:0] exp);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, outs(), exp);
    end
  endtask

  task automatic drive(input logic s, input logic r, input logic w,
                       input logic wd, input logic a);
    sel = s; rd = r; wr = w; wide = wd; a0 = a;
  endtask

  // drive at a falling edge, sample one rising edge later (R2)
  task automatic step(input logic s, input logic r, input logic w,
                      input logic wd, input logic a,
                      input string tag, input logic [10:0] exp);
    @(negedge clk);
    drive(s, r, w, wd, a);
    @(negedge clk);
    check(tag, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with a live transfer at the inputs
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check("R1", 11'b0);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 11'b0);

    // table walk, selected, every strobe/width/A0 pattern
    for (int i = 0; i < 16; i++) begin
      logic [3:0] v;
      v = 4'(i);
      step(1'b1, v[3], v[2], v[1], v[0], TAG_TABLE[i], EXP_TABLE[i]);
    end

    // R3: deselected with every strobe/width/A0 pattern -> all off, no ack
    for (int i = 0; i < 16; i++) begin
      logic [3:0] v;
      v = 4'(i);
      step(1'b0, v[3], v[2], v[1], v[0], "R3", 11'b0);
    end

    // R2: the output tracks the previous edge only
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);        // wide read
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);        // byte write odd
    check("R2", EXP_TABLE[10]);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R2", EXP_TABLE[5]);
    @(negedge clk);
    check("R2", 11'b0);

    // R12: bridge paths followed at once by the Data-In lane paths
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R12", EXP_TABLE[8]);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R12", EXP_TABLE[10]);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R12", EXP_TABLE[5]);

    // R1: reset in the middle of a transfer clears at the next edge
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    check("R4", EXP_TABLE[6]);
    rst = 1'b1;
    @(negedge clk);
    check("R1", 11'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", EXP_TABLE[6]);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule